// File: doc/BRIEF.md
# Packet Page Allocator and Queue Manager

This block owns a small pool of fixed-size packet pages and the bookkeeping around them. One bit per page in an allocation mask records which pages are in use. Three short queues of page numbers follow the life of a frame: a transmit queue of pages waiting to go out, a receive queue of pages holding arrived frames, and a completion queue of pages already sent. Packet memory and the network MAC sit outside the block; they only see page numbers.

A host drives the block through a byte-wide register port with eight addresses. A command byte written to address 0 carries a 3-bit opcode in bits 7:5. The opcodes allocate, release, enqueue, pop and clear. The receive side asks for a page with a level request and gets a one-cycle completion that carries the page number or a rejection. A transmit-launch strobe drains the transmit queue. Each launched page is either freed at once or logged in the completion queue. An 8-bit interrupt status register, partly driven by queue state, is masked into a single interrupt line.

A transmit allocation that finds no free page is not lost. The allocation result register holds 0x80 and the block retries on the next page release. That release may come from the host, from the receive-queue release command or from an auto-released transmit page.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the interrupt status (address 6) reads 0x04, the interrupt mask (address 7) reads 0x00, the allocation result (address 2) reads 0x00, the used-page count (address 5) reads 0, both queue heads (addresses 3 and 4) read 0x80, and irq is low.
- R2: Command 1 (byte 0x20 at address 0) sets the allocation result to the lowest-numbered free page, marks it used and sets status bit 3 (0x08). When every page is used, the result becomes 0x80 and status bit 3 is cleared.
- R3: While the allocation result holds 0x80, any page release (command 4, command 5 or an auto-released transmit page) at once allocates the lowest free page, stores it in the result register and sets status bit 3.
- R4: Command 5 (0xA0) frees the page whose number was last written to the packet-number register (address 1, low bits).
- R5: A held rxReq is answered by a one-cycle rxDone. When a page is free, rxOk is high, rxPage gives the lowest free page, that page is marked used and pushed on the receive queue, and status bit 0 (0x01) is set. When no page is free, rxOk is low and nothing changes.
- R6: Command 3 (0x60) pops the receive queue. Command 4 (0x80) first frees the head page and then pops. After either pop, status bit 0 stays set only if entries remain. The receive head (address 4) reads 0x80 when the queue is empty, and a pop of an empty queue leaves it empty.
- R7: Command 6 (0xC0) appends the packet-number register to the transmit queue, which holds as many entries as there are pages. A push onto a full transmit queue is dropped. Status bit 2 (0x04) is set whenever the transmit queue is empty and otherwise holds its value until acknowledged.
- R8: A txGo pulse drains the transmit queue, one page per cycle not taken by the host. With autoRelease high each page is freed. With it low each page is pushed on the completion queue (head at address 3). Status bit 1 (0x02) is set whenever the completion queue is non-empty.
- R9: A write to address 6 clears only the status bits selected by the written value AND 0xD6. If bit 1 is among them, one entry is popped from the completion queue.
- R10: irq is high exactly when the interrupt status AND the mask written at address 7 is non-zero.
- R11: Command 2 (0x40) empties all three queues, frees every page and sets the allocation result to 0x00. Command 7 (0xE0) empties the transmit and completion queues and keeps page allocation as it is.
- R12: Address 5 reads the number of pages currently marked used.
- R13: Only one operation takes effect per cycle, with priority host write, then transmit drain, then receive request. rxDone stays low in a cycle with a host write. A txGo pulse that coincides with a host write is remembered and served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for one cycle |
| hostAddr | input | 3 | Register address for both reads and writes |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Combinational read data at hostAddr |
| autoRelease | input | 1 | Free transmitted pages instead of logging them |
| txGo | input | 1 | Transmit-launch pulse |
| rxReq | input | 1 | Receive page request, held until rxDone |
| rxDone | output | 1 | Receive request answered this cycle |
| rxOk | output | 1 | Page granted, valid with rxDone |
| rxPage | output | PAGE_W | Granted page number, valid with rxDone and rxOk |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills the pool one allocation at a time. For each page in turn it frees that page while an allocation is pending. A design that forgets the pending request, or that retries from the wrong end of the mask, shows the wrong result register. Every mask value is written against a known status to pin down the interrupt AND. An acknowledge of all ones must leave the receive and allocation flags alone and leave the queue-driven transmit-empty flag set. A fifth transmit push on a full queue must be dropped, which the bench checks by counting completion entries as it acknowledges them one by one. The bench also collides a host write with a receive request and with a launch pulse, so a design that loses either one, or serves two operations in one cycle, ends with a wrong completion head or a wrong rxDone.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

  localparam logic [7:0] NO_PAGE  = 8'h80;
  localparam logic [7:0] ACK_MASK = 8'hD6;

  localparam int ST_RCV     = 0;
  localparam int ST_TXDONE  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_ALLOC   = 3;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ALLOC     = 3'd1,
    OP_WIPE      = 3'd2,
    OP_RXPOP     = 3'd3,
    OP_RXRELPOP  = 3'd4,
    OP_RELEASE   = 3'd5,
    OP_TXPUSH    = 3'd6,
    OP_TXCLEAR   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    A_CMD      = 3'd0,
    A_PKTNUM   = 3'd1,
    A_ALLOCRES = 3'd2,
    A_DONEHEAD = 3'd3,
    A_RXHEAD   = 3'd4,
    A_USED     = 3'd5,
    A_STATUS   = 3'd6,
    A_MASK     = 3'd7
  } addr_e;

  typedef struct packed {
    logic cmdAlloc;
    logic cmdWipe;
    logic cmdRxPop;
    logic cmdRxRelPop;
    logic cmdRelease;
    logic cmdTxPush;
    logic cmdTxClear;
    logic wrPktNum;
    logic wrAck;
    logic wrMask;
    logic txStep;
    logic rxAlloc;
  } strobe_t;

endpackage

// File: rtl/pkt_page_fifo.sv
module pkt_page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] rdPtr, wrPtr;
  logic [CW-1:0]   cnt;
  logic            doPop, doPush;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    bump = (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPop  = pop && (cnt != '0);
  assign doPush = push && ((cnt != CW'(DEPTH)) || doPop);

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      cnt <= cnt + CW'(doPush) - CW'(doPop);
    end
  end

  assign head  = mem[rdPtr];
  assign count = cnt;
  assign empty = (cnt == '0);

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop && !clr && (cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH))); // R7

  AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rstN)
    pop && !push && !clr && (cnt == '0) |=> (cnt == '0)); // R6

endmodule

// File: rtl/pkt_page_ctrl.sv
module pkt_page_ctrl
  import pkt_page_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic [2:0] hostAddr,
  input  logic [2:0] opField,
  input  logic       txGo,
  input  logic       rxReq,
  input  logic       txLast,
  output strobe_t    stb,
  output logic       rxDone
);
  logic txPend;
  logic txSlot, rxSlot;
  op_e  op;

  assign op     = op_e'(opField);
  assign txSlot = !hostWrEn && txPend;
  assign rxSlot = !hostWrEn && !txPend && rxReq;
  assign rxDone = rxSlot;

  always_ff @(posedge clk) begin
    if (!rstN) txPend <= 1'b0;
    else       txPend <= txGo || (txPend && !(txSlot && txLast));
  end

  always_comb begin
    stb         = '0;
    stb.txStep  = txSlot;
    stb.rxAlloc = rxSlot;
    if (hostWrEn) begin
      case (hostAddr)
        A_CMD: begin
          unique case (op)
            OP_NOP:      ;
            OP_ALLOC:    stb.cmdAlloc    = 1'b1;
            OP_WIPE:     stb.cmdWipe     = 1'b1;
            OP_RXPOP:    stb.cmdRxPop    = 1'b1;
            OP_RXRELPOP: stb.cmdRxRelPop = 1'b1;
            OP_RELEASE:  stb.cmdRelease  = 1'b1;
            OP_TXPUSH:   stb.cmdTxPush   = 1'b1;
            OP_TXCLEAR:  stb.cmdTxClear  = 1'b1;
          endcase
        end
        A_PKTNUM: stb.wrPktNum = 1'b1;
        A_STATUS: stb.wrAck    = 1'b1;
        A_MASK:   stb.wrMask   = 1'b1;
        default:  ;
      endcase
    end
  end

  AST_HOST_BEFORE_RX: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> !rxDone); // R13

  AST_LAUNCH_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    txGo |=> txPend); // R13

endmodule

// File: rtl/pkt_page_dp.sv
module pkt_page_dp
  import pkt_page_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [7:0]    wrData,
  input  logic [2:0]    rdAddr,
  input  logic          autoRelease,
  output logic [7:0]    rdData,
  output logic          irq,
  output logic          rxOk,
  output logic [PW-1:0] rxPage,
  output logic          txLast
);
  localparam int CW = $clog2(NP + 1);

  logic [NP-1:0] allocMask, maskRel, maskN;
  logic [7:0]    allocRes, resN;
  logic [7:0]    intStat, effStat, statN, intMask;
  logic [PW-1:0] pktNum;

  logic [PW-1:0] txHead, rxHead, dnHead;
  logic [CW-1:0] txCount, rxCount, dnCount;
  logic          txEmpty, rxEmpty, dnEmpty;
  logic          txPush, txPop, txClr, rxPush, rxPop, rxClr, dnPush, dnPop, dnClr;

  logic          relValid;
  logic [PW-1:0] relPage, lfNow, lfRel;

  function automatic logic [PW-1:0] lowFree(input logic [NP-1:0] m);
    lowFree = '0;
    for (int i = NP - 1; i >= 0; i--) if (!m[i]) lowFree = PW'(i);
  endfunction

  function automatic logic [7:0] usedCount(input logic [NP-1:0] m);
    usedCount = '0;
    for (int i = 0; i < NP; i++) usedCount = usedCount + 8'(m[i]);
  endfunction

  pkt_page_fifo #(.DEPTH(NP), .W(PW), .CW(CW)) u_txQ (
    .clk(clk), .rstN(rstN), .clr(txClr), .push(txPush), .pushData(pktNum),
    .pop(txPop), .head(txHead), .count(txCount), .empty(txEmpty));

  pkt_page_fifo #(.DEPTH(NP), .W(PW), .CW(CW)) u_rxQ (
    .clk(clk), .rstN(rstN), .clr(rxClr), .push(rxPush), .pushData(lfNow),
    .pop(rxPop), .head(rxHead), .count(rxCount), .empty(rxEmpty));

  pkt_page_fifo #(.DEPTH(NP), .W(PW), .CW(CW)) u_doneQ (
    .clk(clk), .rstN(rstN), .clr(dnClr), .push(dnPush), .pushData(txHead),
    .pop(dnPop), .head(dnHead), .count(dnCount), .empty(dnEmpty));

  // status seen by the host: stored bits plus the queue-driven flags
  always_comb begin
    effStat = intStat;
    if (txEmpty)  effStat[ST_TXEMPTY] = 1'b1;
    if (!dnEmpty) effStat[ST_TXDONE]  = 1'b1;
  end

  assign irq    = |(effStat & intMask);
  assign txLast = (txCount <= CW'(1));
  assign lfNow  = lowFree(allocMask);
  assign rxPage = lfNow;

  // which page, if any, is freed by this cycle's operation
  always_comb begin
    relValid = 1'b0;
    relPage  = '0;
    if (stb.cmdRxRelPop && !rxEmpty) begin relValid = 1'b1; relPage = rxHead; end
    if (stb.cmdRelease)              begin relValid = 1'b1; relPage = pktNum; end
    if (stb.txStep && autoRelease && !txEmpty) begin relValid = 1'b1; relPage = txHead; end
    maskRel = relValid ? (allocMask & ~(NP'(1) << relPage)) : allocMask;
    lfRel   = lowFree(maskRel);
  end

  always_comb begin
    maskN  = maskRel;
    resN   = allocRes;
    statN  = effStat;
    rxOk   = 1'b0;
    txPush = 1'b0; txPop = 1'b0; txClr = 1'b0;
    rxPush = 1'b0; rxPop = 1'b0; rxClr = 1'b0;
    dnPush = 1'b0; dnPop = 1'b0; dnClr = 1'b0;

    if (stb.cmdAlloc) begin
      resN            = NO_PAGE;
      statN[ST_ALLOC] = 1'b0;
      if (!(&allocMask)) begin
        maskN[lfNow]    = 1'b1;
        resN            = 8'(lfNow);
        statN[ST_ALLOC] = 1'b1;
      end
    end
    if (relValid && (allocRes == NO_PAGE) && !(&maskRel)) begin
      maskN[lfRel]    = 1'b1;
      resN            = 8'(lfRel);
      statN[ST_ALLOC] = 1'b1;
    end
    if (stb.rxAlloc && !(&allocMask)) begin
      rxOk          = 1'b1;
      maskN[lfNow]  = 1'b1;
      rxPush        = 1'b1;
      statN[ST_RCV] = 1'b1;
    end
    if (stb.cmdRxPop || stb.cmdRxRelPop) begin
      rxPop         = 1'b1;
      statN[ST_RCV] = (rxCount > CW'(1));
    end
    if (stb.cmdWipe) begin
      maskN = '0;
      resN  = '0;
      txClr = 1'b1; rxClr = 1'b1; dnClr = 1'b1;
    end
    if (stb.cmdTxClear) begin
      txClr = 1'b1; dnClr = 1'b1;
    end
    if (stb.cmdTxPush) txPush = 1'b1;
    if (stb.txStep && !txEmpty) begin
      txPop  = 1'b1;
      dnPush = !autoRelease;
    end
    if (stb.wrAck) begin
      statN = effStat & ~(wrData & ACK_MASK);
      dnPop = wrData[ST_TXDONE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocMask <= '0;
      allocRes  <= '0;
      intStat   <= 8'h04;
      intMask   <= '0;
      pktNum    <= '0;
    end else begin
      allocMask <= maskN;
      allocRes  <= resN;
      intStat   <= statN;
      if (stb.wrMask)   intMask <= wrData;
      if (stb.wrPktNum) pktNum  <= wrData[PW-1:0];
    end
  end

  always_comb begin
    case (addr_e'(rdAddr))
      A_PKTNUM:   rdData = 8'(pktNum);
      A_ALLOCRES: rdData = allocRes;
      A_DONEHEAD: rdData = dnEmpty ? NO_PAGE : 8'(dnHead);
      A_RXHEAD:   rdData = rxEmpty ? NO_PAGE : 8'(rxHead);
      A_USED:     rdData = usedCount(allocMask);
      A_STATUS:   rdData = effStat;
      A_MASK:     rdData = intMask;
      default:    rdData = 8'h00;
    endcase
  end

  AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmdAlloc && !(&allocMask) |=> (allocRes != NO_PAGE) && allocMask[allocRes[PW-1:0]]); // R2

  AST_ALLOC_NONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmdAlloc && (&allocMask) |=> (allocRes == NO_PAGE) && !intStat[ST_ALLOC]); // R2

  AST_PENDING_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    relValid && (allocRes == NO_PAGE) |=> (allocRes != NO_PAGE) && intStat[ST_ALLOC]); // R3

  AST_RX_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxAlloc && (&allocMask) |=> (allocMask == $past(allocMask))); // R5

  AST_RX_LAST_POP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdRxPop || stb.cmdRxRelPop) && (rxCount <= CW'(1)) |=> !intStat[ST_RCV]); // R6

  AST_ACK_SPARES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAck |=> (intStat[ST_RCV] == $past(intStat[ST_RCV]))
               && (intStat[ST_ALLOC] == $past(intStat[ST_ALLOC]))); // R9

  AST_ACK_LAST_DONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAck && wrData[ST_TXDONE] && (dnCount == CW'(1)) |=> !effStat[ST_TXDONE]); // R9

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [2:0]        hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  logic              autoRelease,
  input  logic              txGo,
  input  logic              rxReq,
  output logic              rxDone,
  output logic              rxOk,
  output logic [PAGE_W-1:0] rxPage,
  output logic              irq
);
  strobe_t stb;
  logic    txLast;
  logic    dpRxOk;

  pkt_page_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .opField(hostWrData[7:5]), .txGo(txGo), .rxReq(rxReq), .txLast(txLast),
    .stb(stb), .rxDone(rxDone));

  pkt_page_dp #(.NP(NUM_PAGES), .PW(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostWrData), .rdAddr(hostAddr),
    .autoRelease(autoRelease), .rdData(hostRdData), .irq(irq), .rxOk(dpRxOk),
    .rxPage(rxPage), .txLast(txLast));

  assign rxOk = rxDone && dpRxOk;

endmodule

// File: tb/sim_pkt_page_mgr.sv
module sim_pkt_page_mgr;
  localparam int NP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [2:0] hostAddr = 3'd0;
  logic [7:0] hostWrData = 8'd0;
  logic [7:0] hostRdData;
  logic       autoRelease = 1'b0;
  logic       txGo = 1'b0;
  logic       rxReq = 1'b0;
  logic       rxDone, rxOk, irq;
  logic [1:0] rxPage;

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pkt_page_mgr #(.NUM_PAGES(NP)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .autoRelease(autoRelease),
    .txGo(txGo), .rxReq(rxReq), .rxDone(rxDone), .rxOk(rxOk), .rxPage(rxPage),
    .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] a, input logic [7:0] bits,
                       input logic [7:0] exp);
    hostAddr = a;
    #1;
    chk(tag, int'(hostRdData & bits), int'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic launch();
    @(negedge clk); txGo = 1'b1;
    @(negedge clk); txGo = 1'b0;
    idle(NP + 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 status", 3'd6, 8'hFF, 8'h04);
    rdChk("R1 mask", 3'd7, 8'hFF, 8'h00);
    rdChk("R1 allocres", 3'd2, 8'hFF, 8'h00);
    rdChk("R1 used", 3'd5, 8'hFF, 8'h00);
    rdChk("R1 rxhead", 3'd4, 8'hFF, 8'h80);
    rdChk("R1 donehead", 3'd3, 8'hFF, 8'h80);
    chk("R1 irq", int'(irq), 0);

    // R2 allocation sweep, R12 used count
    for (int i = 0; i < NP; i++) begin
      wr(3'd0, 8'h20);
      rdChk("R2 alloc page", 3'd2, 8'hFF, 8'(i));
      rdChk("R2 alloc flag", 3'd6, 8'h08, 8'h08);
      rdChk("R12 used", 3'd5, 8'hFF, 8'(i + 1));
    end
    wr(3'd0, 8'h20);
    rdChk("R2 full result", 3'd2, 8'hFF, 8'h80);
    rdChk("R2 full flag", 3'd6, 8'h08, 8'h00);

    // R3 / R4 pending retry on each released page
    for (int k = 0; k < NP; k++) begin
      wr(3'd1, 8'(k));
      wr(3'd0, 8'hA0);
      rdChk("R3 retry page", 3'd2, 8'hFF, 8'(k));
      rdChk("R3 retry flag", 3'd6, 8'h08, 8'h08);
      rdChk("R4 used after release+retry", 3'd5, 8'hFF, 8'(NP));
      wr(3'd0, 8'h20);
      rdChk("R2 pending again", 3'd2, 8'hFF, 8'h80);
    end

    // R11 wipe
    wr(3'd0, 8'h40);
    rdChk("R11 wipe used", 3'd5, 8'hFF, 8'h00);
    rdChk("R11 wipe allocres", 3'd2, 8'hFF, 8'h00);

    // R5 receive requests
    for (int i = 0; i <= NP; i++) begin
      @(negedge clk); rxReq = 1'b1;
      #1;
      chk("R5 rxDone", int'(rxDone), 1);
      chk("R5 rxOk", int'(rxOk), (i < NP) ? 1 : 0);
      if (i < NP) chk("R5 rxPage", int'(rxPage), i);
      @(negedge clk); rxReq = 1'b0;
    end
    rdChk("R5 rxhead", 3'd4, 8'hFF, 8'h00);
    rdChk("R5 status", 3'd6, 8'hFF, 8'h05);
    rdChk("R12 used rx", 3'd5, 8'hFF, 8'(NP));

    // R10 exhaustive mask sweep against status 0x05
    for (int m = 0; m < 256; m++) begin
      wr(3'd7, 8'(m));
      chk("R10 irq", int'(irq), ((m & 5) != 0) ? 1 : 0);
    end
    wr(3'd7, 8'h00);

    // R9 all-ones acknowledge spares receive flag; tx-empty stays forced
    wr(3'd6, 8'hFF);
    rdChk("R9 ack spares", 3'd6, 8'hFF, 8'h05);

    // R6 receive pops
    wr(3'd0, 8'h60);
    rdChk("R6 pop head", 3'd4, 8'hFF, 8'h01);
    rdChk("R6 flag kept", 3'd6, 8'h01, 8'h01);
    wr(3'd0, 8'h80);
    rdChk("R6 relpop head", 3'd4, 8'hFF, 8'h02);
    rdChk("R6 relpop used", 3'd5, 8'hFF, 8'h03);
    wr(3'd0, 8'h60);
    rdChk("R6 head 3", 3'd4, 8'hFF, 8'h03);
    wr(3'd0, 8'h60);
    rdChk("R6 empty head", 3'd4, 8'hFF, 8'h80);
    rdChk("R6 flag cleared", 3'd6, 8'h01, 8'h00);
    wr(3'd0, 8'h60);
    rdChk("R6 empty pop", 3'd4, 8'hFF, 8'h80);
    rdChk("R6 used kept", 3'd5, 8'hFF, 8'h03);

    // R7 transmit queue
    wr(3'd0, 8'h40);
    for (int i = 0; i < NP; i++) wr(3'd0, 8'h20);
    rdChk("R2 last alloc", 3'd2, 8'hFF, 8'(NP - 1));
    for (int i = 0; i < NP; i++) begin
      wr(3'd1, 8'(i));
      wr(3'd0, 8'hC0);
    end
    rdChk("R7 empty flag sticky", 3'd6, 8'h04, 8'h04);
    wr(3'd6, 8'h04);
    rdChk("R7 empty flag acked", 3'd6, 8'h04, 8'h00);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'hC0);                       // fifth push, dropped

    // R8 launch without auto-release
    autoRelease = 1'b0;
    launch();
    rdChk("R8 done head", 3'd3, 8'hFF, 8'h00);
    rdChk("R8 done flag", 3'd6, 8'h02, 8'h02);
    rdChk("R7 empty forced", 3'd6, 8'h04, 8'h04);
    rdChk("R8 used kept", 3'd5, 8'hFF, 8'(NP));

    // R9 done pops through acknowledge
    for (int i = 1; i <= NP; i++) begin
      wr(3'd6, 8'h02);
      rdChk("R9 done pop", 3'd3, 8'hFF, (i < NP) ? 8'(i) : 8'h80);
    end
    rdChk("R9 done flag gone", 3'd6, 8'h02, 8'h00);

    // R11 clear transmit queues
    wr(3'd1, 8'd1); wr(3'd0, 8'hC0);
    wr(3'd1, 8'd2); wr(3'd0, 8'hC0);
    wr(3'd0, 8'hE0);
    rdChk("R11 txclear empty flag", 3'd6, 8'h04, 8'h04);
    rdChk("R11 txclear used", 3'd5, 8'hFF, 8'(NP));
    launch();
    rdChk("R11 nothing sent", 3'd3, 8'hFF, 8'h80);

    // R8 / R3 auto-release frees page and serves pending allocation
    wr(3'd0, 8'h20);
    rdChk("R2 pending", 3'd2, 8'hFF, 8'h80);
    autoRelease = 1'b1;
    wr(3'd1, 8'd2); wr(3'd0, 8'hC0);
    launch();
    rdChk("R3 auto retry", 3'd2, 8'hFF, 8'h02);
    rdChk("R8 auto no log", 3'd3, 8'hFF, 8'h80);
    autoRelease = 1'b0;

    // R13 arbitration
    wr(3'd0, 8'h40);
    @(negedge clk);
    rxReq = 1'b1; hostWrEn = 1'b1; hostAddr = 3'd7; hostWrData = 8'h00;
    #1;
    chk("R13 rx waits", int'(rxDone), 0);
    @(negedge clk);
    hostWrEn = 1'b0;
    #1;
    chk("R13 rx served", int'(rxDone), 1);
    chk("R13 rx page", int'(rxPage), 0);
    @(negedge clk); rxReq = 1'b0;
    wr(3'd0, 8'h20);
    rdChk("R13 alloc next", 3'd2, 8'hFF, 8'h01);
    wr(3'd1, 8'd1);
    @(negedge clk);
    txGo = 1'b1; hostWrEn = 1'b1; hostAddr = 3'd0; hostWrData = 8'hC0;
    @(negedge clk);
    txGo = 1'b0; hostWrEn = 1'b0;
    idle(3);
    rdChk("R13 launch kept", 3'd3, 8'hFF, 8'h01);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule